// File: doc/BRIEF.md
# Double-Buffered PWM Output Channel

This block is one timer channel that produces a pulse-width-modulated output from its own up-counter. The counter starts at 1 and counts up to the active period value (B). Then it reloads to 1. The clock that performs the reload is the cycle boundary. Reaching the active edge value (A) drives the output to one level, and reaching B drives it to the other. A polarity input selects which level belongs to which match.

Software writes the next A and B values into staging registers at any time. Both staged values move into the active compare registers together. The transfer is a one-clock load strobe on the last system clock of a counter cycle, so a new setting never takes effect in the middle of a period. A hold input suppresses the transfer, so several channels can be changed in step. The counter advances through two chained prescalers. A registered flag reports matches, either B only or A and B, and has a clear input.

Top module: `dbuf_pwm_channel`

## Requirements
- R1: After reset, `pwm_out` is 0, `flag` is 0 and `count` is 1.
- R2: While `enable` is high, `count` steps once every (`chan_div`+1)·(`glob_div`+1) system clocks. It counts 1, 2, … up to the active B value, then reloads to 1, so a period lasts B counter steps. It also reloads to 1 from the all-ones value. While `enable` is low, `count` and both prescalers hold.
- R3: The load strobe fires on the system clock where the counter reloads to 1. In that clock both staged values are copied into the active registers. A value staged during one counter cycle therefore sets the period and the matches of the next cycle.
- R4: If `upd_hold` is 1 in the boundary clock, that transfer does not happen and the active values stay unchanged. Staged values are kept and transfer at the first boundary where `upd_hold` is 0.
- R5: An A match occurs on the last system clock in which `count` equals active A. A B match occurs on the last system clock in which `count` equals active B. One clock after a B match, `pwm_out` equals `edge_pol`. One clock after an A match without a B match, `pwm_out` equals the inverse of `edge_pol`. When both match in the same clock, B wins.
- R6: Since `count` is never 0, an active A of 0 never matches. With `edge_pol` 0 the output then stays at 0 for the whole period.
- R7: With `flag_both` at 0, only B matches set `flag`. With `flag_both` at 1, A matches also set it.
- R8: `flag` rises one clock after a set event. `flag_clr` at 1 clears it one clock later. When a set event and `flag_clr` coincide, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel run enable |
| chan_div | input | 2 | Channel prescaler ratio minus one (1..4) |
| glob_div | input | 2 | Global prescaler ratio minus one (1..4) |
| edge_pol | input | 1 | Output level driven on a B match |
| flag_both | input | 1 | 1: A and B matches set the flag; 0: B only |
| upd_hold | input | 1 | Blocks the boundary transfer of staged values |
| a_wr | input | 1 | Write strobe for the staged A value |
| a_wdata | input | CNT_W | Staged A value |
| b_wr | input | 1 | Write strobe for the staged B value |
| b_wdata | input | CNT_W | Staged B value |
| flag_clr | input | 1 | Clears the flag |
| pwm_out | output | 1 | PWM output |
| flag | output | 1 | Match flag |
| count | output | CNT_W | Channel counter |

## Verification
The bench measures the period between boundaries before and after staged writes. A design that transferred values in the middle of a cycle would produce one truncated or stretched period. It holds `upd_hold` across several boundaries and then releases it. A design that ignored the hold, or lost the staged value, would show the new period too early or never. It programs A as 0 with `edge_pol` 0 and expects a flat low output. It asserts `flag_clr` continuously across B matches. A design that let clear win would never show the flag. With prescaler ratios of 2 and 2 it expects four clocks per count step.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    // registered state of the output stage
    typedef struct packed {
        logic pwm;
        logic flag;
    } out_state_t;

    // number of chained prescaler stages (channel, global)
    localparam int PRESC_STAGES = 2;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic [DIV_W-1:0] ratio_m1,
    output logic             tick_out
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        tick_out = tick_in && (cnt_q == ratio_m1);
        if (tick_in) begin
            cnt_d = tick_out ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             upd_hold,
    input  logic             a_wr,
    input  logic [CNT_W-1:0] a_wdata,
    input  logic             b_wr,
    input  logic [CNT_W-1:0] b_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] a_act,
    output logic [CNT_W-1:0] b_act,
    output logic [CNT_W-1:0] a_stg,
    output logic [CNT_W-1:0] b_stg,
    output logic             load,
    output logic             a_hit,
    output logic             b_hit
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] a_stg;
        logic [CNT_W-1:0] b_stg;
        logic [CNT_W-1:0] a_act;
        logic [CNT_W-1:0] b_act;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        a_hit = step && (st_q.cnt == st_q.a_act);
        b_hit = step && (st_q.cnt == st_q.b_act);
        load  = step && ((st_q.cnt == st_q.b_act) || (st_q.cnt == CNT_TOP));

        if (load)      st_d.cnt = CNT_ONE;
        else if (step) st_d.cnt = st_q.cnt + 1'b1;

        if (load && !upd_hold) begin
            st_d.a_act = st_q.a_stg;
            st_d.b_act = st_q.b_stg;
        end

        if (a_wr) st_d.a_stg = a_wdata;
        if (b_wr) st_d.b_stg = b_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= CNT_ONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt   = st_q.cnt;
    assign a_act = st_q.a_act;
    assign b_act = st_q.b_act;
    assign a_stg = st_q.a_stg;
    assign b_stg = st_q.b_stg;
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage
    import pwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_hit,
    input  logic b_hit,
    input  logic edge_pol,
    input  logic flag_both,
    input  logic flag_clr,
    output logic pwm_out,
    output logic flag
);
    out_state_t os_d, os_q;
    logic       set_ev;

    always_comb begin
        os_d   = os_q;
        set_ev = b_hit || (flag_both && a_hit);

        if (b_hit)      os_d.pwm = edge_pol;
        else if (a_hit) os_d.pwm = ~edge_pol;

        if (set_ev)        os_d.flag = 1'b1;
        else if (flag_clr) os_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) os_q <= '0;
        else        os_q <= os_d;
    end

    assign pwm_out = os_q.pwm;
    assign flag    = os_q.flag;
endmodule

// File: rtl/dbuf_pwm_channel.sv
module dbuf_pwm_channel
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] chan_div,
    input  logic [DIV_W-1:0] glob_div,
    input  logic             edge_pol,
    input  logic             flag_both,
    input  logic             upd_hold,
    input  logic             a_wr,
    input  logic [CNT_W-1:0] a_wdata,
    input  logic             b_wr,
    input  logic [CNT_W-1:0] b_wdata,
    input  logic             flag_clr,
    output logic             pwm_out,
    output logic             flag,
    output logic [CNT_W-1:0] count
);
    logic [PRESC_STAGES:0]   tick_chain;
    logic [DIV_W-1:0]        stage_ratio [PRESC_STAGES];
    logic [CNT_W-1:0]        a_act, b_act, a_stg, b_stg;
    logic                    load, a_hit, b_hit;

    assign tick_chain[0]  = enable;
    assign stage_ratio[0] = chan_div;
    assign stage_ratio[1] = glob_div;

    for (genvar s = 0; s < PRESC_STAGES; s++) begin : g_presc
        pwm_prescaler #(.DIV_W(DIV_W)) u_presc (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_in  (tick_chain[s]),
            .ratio_m1 (stage_ratio[s]),
            .tick_out (tick_chain[s+1])
        );
    end

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (tick_chain[PRESC_STAGES]),
        .upd_hold (upd_hold),
        .a_wr     (a_wr),
        .a_wdata  (a_wdata),
        .b_wr     (b_wr),
        .b_wdata  (b_wdata),
        .cnt      (count),
        .a_act    (a_act),
        .b_act    (b_act),
        .a_stg    (a_stg),
        .b_stg    (b_stg),
        .load     (load),
        .a_hit    (a_hit),
        .b_hit    (b_hit)
    );

    pwm_outstage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_hit     (a_hit),
        .b_hit     (b_hit),
        .edge_pol  (edge_pol),
        .flag_both (flag_both),
        .flag_clr  (flag_clr),
        .pwm_out   (pwm_out),
        .flag      (flag)
    );
endmodule

// File: rtl/dbuf_pwm_channel_chk.sv
module dbuf_pwm_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             edge_pol,
    input logic             flag_both,
    input logic             upd_hold,
    input logic             flag_clr,
    input logic             load,
    input logic             a_hit,
    input logic             b_hit,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] a_act,
    input logic [CNT_W-1:0] b_act,
    input logic [CNT_W-1:0] a_stg,
    input logic [CNT_W-1:0] b_stg,
    input logic             pwm_out,
    input logic             flag
);
    // R2
    reload_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == CNT_W'(1)));
    // R2
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(count));
    // R3
    transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !upd_hold) |=> (a_act == $past(a_stg)) && (b_act == $past(b_stg)));
    // R4
    blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && upd_hold) |=> $stable(a_act) && $stable(b_act));
    // R5
    b_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_hit |=> (pwm_out == $past(edge_pol)));
    // R5
    a_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_hit && !b_hit) |=> (pwm_out != $past(edge_pol)));
    // R6
    never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count != '0);
    // R7
    a_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_hit && flag_both) |=> flag);
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_hit |=> flag);
    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !b_hit && !(a_hit && flag_both)) |=> !flag);
endmodule

bind dbuf_pwm_channel dbuf_pwm_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .edge_pol  (edge_pol),
    .flag_both (flag_both),
    .upd_hold  (upd_hold),
    .flag_clr  (flag_clr),
    .load      (load),
    .a_hit     (a_hit),
    .b_hit     (b_hit),
    .count     (count),
    .a_act     (a_act),
    .b_act     (b_act),
    .a_stg     (a_stg),
    .b_stg     (b_stg),
    .pwm_out   (pwm_out),
    .flag      (flag)
);

// File: tb/sim_dbuf_pwm_channel.sv
`timescale 1ns/1ps
module sim_dbuf_pwm_channel;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic [1:0]   chan_div = '0, glob_div = '0;
    logic         edge_pol = 1'b0, flag_both = 1'b0, upd_hold = 1'b0;
    logic         a_wr = 1'b0, b_wr = 1'b0, flag_clr = 1'b0;
    logic [W-1:0] a_wdata = '0, b_wdata = '0;
    logic         pwm_out, flag;
    logic [W-1:0] count;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dbuf_pwm_channel #(.CNT_W(W), .DIV_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .chan_div(chan_div),
        .glob_div(glob_div), .edge_pol(edge_pol), .flag_both(flag_both),
        .upd_hold(upd_hold), .a_wr(a_wr), .a_wdata(a_wdata), .b_wr(b_wr),
        .b_wdata(b_wdata), .flag_clr(flag_clr), .pwm_out(pwm_out),
        .flag(flag), .count(count)
    );

    // scoreboard items
    typedef struct {
        logic         pwm;
        logic         flg;
        logic [W-1:0] cnt;
    } exp_t;
    exp_t exp_q[$];

    // behavioural model written from the requirements
    int           m_pc, m_gc;
    logic [W-1:0] m_cnt, m_as, m_bs, m_aa, m_ba;
    logic         m_pwm, m_flg;

    always @(posedge clk) begin : model
        bit t1, t2, ah, bh, bnd, st;
        exp_t e;
        if (!rst_n) begin
            m_pc = 0; m_gc = 0; m_cnt = 1; m_as = 0; m_bs = 0;
            m_aa = 0; m_ba = 0; m_pwm = 0; m_flg = 0;
        end else begin
            t1  = enable && (m_pc == int'(chan_div));
            t2  = t1 && (m_gc == int'(glob_div));
            ah  = t2 && (m_cnt == m_aa);
            bh  = t2 && (m_cnt == m_ba);
            bnd = t2 && (m_cnt == m_ba || m_cnt == '1);
            st  = bh || (flag_both && ah);
            if (enable) m_pc = t1 ? 0 : m_pc + 1;
            if (t1)     m_gc = t2 ? 0 : m_gc + 1;
            if (bh)      m_pwm = edge_pol;
            else if (ah) m_pwm = ~edge_pol;
            if (st)            m_flg = 1'b1;
            else if (flag_clr) m_flg = 1'b0;
            if (bnd && !upd_hold) begin m_aa = m_as; m_ba = m_bs; end
            if (bnd)     m_cnt = 1;
            else if (t2) m_cnt = m_cnt + 1'b1;
            if (a_wr) m_as = a_wdata;
            if (b_wr) m_bs = b_wdata;
            e.pwm = m_pwm; e.flg = m_flg; e.cnt = m_cnt;
            exp_q.push_back(e);
        end
    end

    // monitor: compares away from the active edge
    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            checks++;
            if (count !== e.cnt) begin
                errors++;
                $display("FAIL R2 count actual=%0d expected=%0d", count, e.cnt);
            end
            checks++;
            if (pwm_out !== e.pwm) begin
                errors++;
                $display("FAIL R5 pwm_out actual=%b expected=%b", pwm_out, e.pwm);
            end
            checks++;
            if (flag !== e.flg) begin
                errors++;
                $display("FAIL R8 flag actual=%b expected=%b", flag, e.flg);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // waits at negedges until the first clock of a new counter cycle
    task automatic wait_boundary();
        logic [W-1:0] prev = count;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (count == 1 && prev != 1) return;
            prev = count;
        end
    endtask

    task automatic measure_period(output int clocks);
        logic [W-1:0] prev;
        wait_boundary();
        clocks = 0;
        prev = count;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            clocks++;
            if (count == 1 && prev != 1) return;
            prev = count;
        end
    endtask

    task automatic stage(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        a_wr = 1'b1; a_wdata = a; b_wr = 1'b1; b_wdata = b;
        @(negedge clk);
        a_wr = 1'b0; b_wr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : driver
        int p, changes;
        logic last;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pwm_out", pwm_out, 0);
        check("R1 flag", flag, 0);
        check("R1 count", count, 1);
        rst_n = 1'b1;

        edge_pol = 1'b1;
        enable = 1'b1;
        stage(8'd3, 8'd5);
        // R2 first cycle runs to all-ones, then R3 staged B=5 is active
        measure_period(p);
        check("R3 period after transfer", p, 5);
        measure_period(p);
        check("R2 period B=5 ratio 1", p, 5);

        // R3 staging mid-cycle takes effect only from next cycle
        wait_boundary();
        @(negedge clk);
        stage(8'd2, 8'd6);
        measure_period(p);
        check("R3 new period", p, 6);

        // R4 hold blocks transfers across boundaries
        upd_hold = 1'b1;
        stage(8'd2, 8'd9);
        measure_period(p);
        check("R4 held period", p, 6);
        measure_period(p);
        check("R4 held period again", p, 6);
        wait_boundary();
        upd_hold = 1'b0;
        measure_period(p);
        check("R4 released period", p, 9);

        // R7 flag on A matches too
        flag_both = 1'b1;
        repeat (30) @(negedge clk);
        flag_both = 1'b0;

        // R8 clear held high: set still wins on B match
        flag_clr = 1'b1;
        wait_boundary();
        check("R8 set beats clear", flag, 1);
        @(negedge clk);
        check("R8 cleared next clock", flag, 0);
        flag_clr = 1'b0;

        // R2 prescalers 2 x 2: four clocks per step
        chan_div = 2'd1; glob_div = 2'd1;
        measure_period(p);
        measure_period(p);
        check("R2 period with ratio 4", p, 36);

        // R2 disabled counter holds
        enable = 1'b0;
        begin
            logic [W-1:0] c0;
            @(negedge clk);
            c0 = count;
            repeat (12) @(negedge clk);
            check("R2 hold while disabled", count, c0);
        end
        enable = 1'b1;
        chan_div = 2'd0; glob_div = 2'd0;

        // R6 A=0: flat low output with edge_pol 0
        edge_pol = 1'b0;
        stage(8'd0, 8'd7);
        wait_boundary();
        wait_boundary();
        changes = 0;
        last = pwm_out;
        for (int i = 0; i < 21; i++) begin
            @(negedge clk);
            if (pwm_out != last) changes++;
            last = pwm_out;
        end
        check("R6 no transitions", changes, 0);
        check("R6 output low", pwm_out, 0);

        // R5 A and B equal: B wins
        edge_pol = 1'b1;
        stage(8'd4, 8'd4);
        wait_boundary();
        wait_boundary();
        repeat (12) @(negedge clk);
        check("R5 B wins on coincident match", pwm_out, 1);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule